// File: doc/BRIEF.md
# Per-Packet Virtual Channel Allocator

This block performs admission control for the virtual channels of one service level on one output port. Input virtual channels raise a header request when a packet's first flit is waiting. The block takes one such request at a time through a round-robin arbiter. It then claims a free output virtual channel for that packet. The winner's index is recorded in the chosen output channel, and that channel is marked busy.

The grant stays with the same input for as long as its header request stays high. This ties each request to exactly one output channel. An output channel stays busy until its owner reports that the handshake for the packet's tail flit has finished. At that point the channel forgets its owner and can be claimed again.

Body and tail flits never pass through this block. They move directly between the paired input and output channels once the pairing exists. The number of requesters is a power of two, and the number of output channels is free.

Top module: `vc_admit`

## Requirements
- R1: During and right after reset, `grant` is all zero, every `vc_busy` bit is 0 and every field of `vc_src` is 0.
- R2: An assignment happens only in a cycle with no grant outstanding, at least one `hdr_req` bit high and at least one `vc_busy` bit low. When no request is present or no channel is free, nothing changes and the requests wait.
- R3: Requests are taken round-robin. The winner is the first requesting input at or after a pointer, counting upward and wrapping. The pointer is 0 after reset and moves to one past the winner after each assignment.
- R4: The assigned output channel is the lowest-numbered one whose `vc_busy` bit is low in the cycle of the assignment.
- R5: One cycle after an assignment, `grant` is one-hot at the winner and `assign_vc` holds the channel number. That channel's `vc_busy` bit is 1, and its `SRC_W`-bit field of `vc_src` (bits v*SRC_W upward) holds the winner's index plus one. No other channel's bit or field changes.
- R6: While the granted input keeps `hdr_req` high, `grant` and `assign_vc` hold and no other assignment is made. In the cycle after that request is seen low, `grant` returns to zero. The next assignment can be made one cycle later at the earliest.
- R7: A `tail_done` pulse on a busy channel clears its `vc_busy` bit and its `vc_src` field to zero in the next cycle. That channel can be assigned again from then on. A pulse on a channel that is not busy has no effect.
- R8: `grant` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_req | input | NUM_IN | Header request per input virtual channel; held until granted, then dropped |
| tail_done | input | NUM_OUT | One-cycle pulse per output channel when its tail handshake has completed |
| grant | output | NUM_IN | One-hot grant to the input whose packet was just admitted |
| assign_vc | output | VC_W | Number of the output channel assigned to the granted input |
| vc_busy | output | NUM_OUT | Busy flag per output channel |
| vc_src | output | NUM_OUT*SRC_W | Per output channel, owning input index plus one; zero when unowned |

## Verification
The bench drives traffic in several phases: sparse requests, saturating requests with no tails at all, and dense mixed traffic. A reference model written with plain integers predicts every output on every cycle.

In the phase with no tails, every channel ends up busy while requests are still pending. A design that fails to stall here would grant without a channel, or would hand out a channel that is already busy. With all inputs requesting, the pointer has to rotate. An arbiter that restarts at zero, or that advances by a fixed step instead of past the winner, would give the wrong grant order.

Tail pulses fall on idle channels as well as busy ones, and on a channel in the same cycle that another channel is being claimed. A design that set busy from a stray tail, or that freed or reloaded the wrong slot, would show a mismatch in `vc_busy` or `vc_src`. Short hold times make requests drop one cycle after their grant. This exposes a design that keeps a stale grant, or that re-admits in the same cycle the grant clears.

// File: rtl/vca_pkg.sv
package vca_pkg;

    // Admission phase of the allocator.
    typedef enum logic {
        ST_OPEN = 1'b0,   // no grant outstanding, may admit
        ST_HOLD = 1'b1    // grant outstanding until its request drops
    } vca_state_e;

endpackage

// File: rtl/vca_rr_pick.sv
// Round-robin selection: first requesting line at or after ptr, wrapping.
module vca_rr_pick #(
    parameter int NUM = 4,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] req,
    input  logic [IW-1:0]  ptr,
    output logic           found,
    output logic [IW-1:0]  idx
);

    logic [IW-1:0] cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        // Scan downward so the smallest offset from ptr is written last.
        for (int k = NUM - 1; k >= 0; k--) begin
            cand = ptr + IW'(k);
            if (req[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/vca_free_pick.sv
// Lowest-numbered channel whose busy flag is low.
module vca_free_pick #(
    parameter int NUM = 3,
    localparam int VW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] busy,
    output logic           found,
    output logic [VW-1:0]  idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int v = NUM - 1; v >= 0; v--) begin
            if (!busy[v]) begin
                found = 1'b1;
                idx   = VW'(v);
            end
        end
    end

endmodule

// File: rtl/vca_slot.sv
// One output virtual channel's ownership record.
module vca_slot #(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SRC_W-1:0] load_src,
    input  logic             release_i,
    output logic             busy,
    output logic [SRC_W-1:0] src
);

    typedef struct packed {
        logic             busy;
        logic [SRC_W-1:0] src;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        // A finished tail frees the channel and forgets the owner.
        if (release_i && slot_q.busy) begin
            slot_d = '0;
        end
        // Admission only ever targets a free channel.
        if (load) begin
            slot_d.busy = 1'b1;
            slot_d.src  = load_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy = slot_q.busy;
    assign src  = slot_q.src;

    AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);  // R4

    AST_TAIL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && busy && !load) |=> (!busy && src == '0));  // R7

    AST_IDLE_TAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !busy && !load) |=> (!busy && src == '0));  // R7

    AST_OWNER_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (src != '0));  // R5

endmodule

// File: rtl/vc_admit.sv
// Admission control for the virtual channels of one service level.
module vc_admit
    import vca_pkg::*;
#(
    parameter int NUM_IN  = 4,   // requesting input channels, power of two
    parameter int NUM_OUT = 3,   // output channels managed here
    localparam int IN_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int VC_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int SRC_W = $clog2(NUM_IN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        hdr_req,
    input  logic [NUM_OUT-1:0]       tail_done,
    output logic [NUM_IN-1:0]        grant,
    output logic [VC_W-1:0]          assign_vc,
    output logic [NUM_OUT-1:0]       vc_busy,
    output logic [NUM_OUT*SRC_W-1:0] vc_src
);

    typedef struct packed {
        vca_state_e        st;
        logic [NUM_IN-1:0] gnt;
        logic [VC_W-1:0]   vc;
        logic [IN_W-1:0]   ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            req_found;
    logic [IN_W-1:0] req_idx;
    logic            free_found;
    logic [VC_W-1:0] free_idx;
    logic            do_assign;
    logic [SRC_W-1:0] win_src;

    vca_rr_pick #(.NUM(NUM_IN)) u_rr (
        .req   (hdr_req),
        .ptr   (ctl_q.ptr),
        .found (req_found),
        .idx   (req_idx)
    );

    vca_free_pick #(.NUM(NUM_OUT)) u_free (
        .busy  (vc_busy),
        .found (free_found),
        .idx   (free_idx)
    );

    assign do_assign = (ctl_q.st == ST_OPEN) && req_found && free_found;
    assign win_src   = SRC_W'(req_idx) + SRC_W'(1);

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.st == ST_OPEN) begin
            if (do_assign) begin
                ctl_d.st  = ST_HOLD;
                ctl_d.gnt = NUM_IN'(1) << req_idx;
                ctl_d.vc  = free_idx;
                ctl_d.ptr = req_idx + IN_W'(1);   // wraps since NUM_IN is 2**IN_W
            end
        end else begin
            if (!(|(hdr_req & ctl_q.gnt))) begin
                ctl_d.st  = ST_OPEN;
                ctl_d.gnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar v = 0; v < NUM_OUT; v++) begin : g_slot
        vca_slot #(.SRC_W(SRC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (do_assign && (free_idx == VC_W'(v))),
            .load_src  (win_src),
            .release_i (tail_done[v]),
            .busy      (vc_busy[v]),
            .src       (vc_src[v*SRC_W +: SRC_W])
        );
    end

    assign grant     = ctl_q.gnt;
    assign assign_vc = ctl_q.vc;

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R8

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & hdr_req)) |=> ($stable(grant) && $stable(assign_vc)));  // R6

    AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !(|(grant & hdr_req))) |=> (grant == '0));  // R6

    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant) |-> ((|($past(hdr_req) & grant)) && (|$past(~vc_busy))));  // R2

    AST_NO_BUSY_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (|hdr_req) == 1'b0) |=> ($countones(vc_busy) <= $countones($past(vc_busy))));  // R2

endmodule

// File: tb/vc_admit_bench.sv
module vc_admit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int M     = 3;
    localparam int VC_W  = 2;
    localparam int SRC_W = 3;
    localparam int CYCLES = 4000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         hdr_req = '0;
    logic [M-1:0]         tail_done = '0;
    logic [N-1:0]         grant;
    logic [VC_W-1:0]      assign_vc;
    logic [M-1:0]         vc_busy;
    logic [M*SRC_W-1:0]   vc_src;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    int m_gnt;
    int m_vc;
    int m_ptr;
    int m_busy [M];
    int m_src  [M];

    // Input channel behaviour.
    int want [N];
    int hold [N];

    vc_admit #(.NUM_IN(N), .NUM_OUT(M)) u_vc_admit (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_req   (hdr_req),
        .tail_done (tail_done),
        .grant     (grant),
        .assign_vc (assign_vc),
        .vc_busy   (vc_busy),
        .vc_src    (vc_src)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        int exp_g;
        exp_g = (m_gnt >= 0) ? (1 << m_gnt) : 0;
        chk(int'(grant), exp_g, "R2/R3/R6 grant");
        chk(int'($countones(grant) <= 1), 1, "R8 grant one-hot");
        if (m_gnt >= 0) chk(int'(assign_vc), m_vc, "R4 assign_vc");
        for (int v = 0; v < M; v++) begin
            chk(int'(vc_busy[v]), m_busy[v], "R5/R7 vc_busy");
            chk(int'(vc_src[v*SRC_W +: SRC_W]), m_src[v], "R5/R7 vc_src");
        end
    endtask

    // Advance the model by one clock with the inputs now applied.
    task automatic model_step();
        int win, fr;
        win = -1;
        fr  = -1;
        if (m_gnt < 0) begin
            for (int k = N - 1; k >= 0; k--)
                if (hdr_req[(m_ptr + k) % N]) win = (m_ptr + k) % N;
            for (int v = M - 1; v >= 0; v--)
                if (m_busy[v] == 0) fr = v;
        end
        for (int v = 0; v < M; v++) begin
            if (tail_done[v] && m_busy[v] != 0) begin   // R7
                m_busy[v] = 0;
                m_src[v]  = 0;
            end
        end
        if (m_gnt >= 0) begin
            if (!hdr_req[m_gnt]) m_gnt = -1;           // R6
        end else if (win >= 0 && fr >= 0) begin        // R2
            m_gnt      = win;
            m_vc       = fr;                            // R4
            m_busy[fr] = 1;
            m_src[fr]  = win + 1;                       // R5
            m_ptr      = (win + 1) % N;                 // R3
        end
    endtask

    task automatic drive(input int cyc);
        int p_req, p_tail;
        if (cyc < 1000) begin
            p_req = 10; p_tail = 30;
        end else if (cyc < 1400) begin
            p_req = 60; p_tail = 0;      // stall phase: channels run out
        end else begin
            p_req = 50; p_tail = 20;
        end
        for (int i = 0; i < N; i++) begin
            if (want[i] != 0) begin
                if (m_gnt == i) begin
                    hold[i]--;
                    if (hold[i] <= 0) want[i] = 0;
                end
            end else if ($urandom_range(0, 99) < p_req) begin
                want[i] = 1;
                hold[i] = $urandom_range(1, 4);
            end
            hdr_req[i] = (want[i] != 0);
        end
        for (int v = 0; v < M; v++)
            tail_done[v] = ($urandom_range(0, 99) < p_tail);
    endtask

    initial begin
        m_gnt = -1;
        m_vc  = 0;
        m_ptr = 0;
        for (int v = 0; v < M; v++) begin
            m_busy[v] = 0;
            m_src[v]  = 0;
        end
        for (int i = 0; i < N; i++) begin
            want[i] = 0;
            hold[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(grant), 0, "R1 grant in reset");
        chk(int'(vc_busy), 0, "R1 vc_busy in reset");
        chk(int'(vc_src), 0, "R1 vc_src in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(grant), 0, "R1 grant after reset");
        chk(int'(vc_busy), 0, "R1 vc_busy after reset");
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            compare();
            drive(cyc);
            model_step();
            @(negedge clk);
        end
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule